// File: doc/BRIEF.md
# Shared-Multiple Transposed FIR Filter

This block is a ten-tap FIR filter in transposed direct form whose coefficients can be rewritten at run time. Each accepted input sample goes to every tap in the same cycle. A single bank of adders forms the odd multiples 1x, 3x, 5x up to 15x of that sample. Every tap reads from that one bank. For each 4-bit group of its coefficient, a tap picks one shared multiple, shifts it and adds it to its partial result, so the taps contain no multipliers of their own.

The products feed a chain of adders and delay registers. The chain advances only when a sample is accepted. The filtered sample leaves through a registered output, one cycle after the input. Coefficients are written one at a time through a small port that carries a tap index, a value and a write strobe.

Top module: `shared_mult_fir`

## Requirements
- R1: For the n-th accepted sample, `y_out` equals the sum over k = 0..9 of c_k·x(n−k). Each c_k is the value tap k held when sample x(n−k) was accepted. Samples from before the last reset count as zero.
- R2: `in_x` and `coef_val` are 17-bit two's complement values and `y_out` is a 38-bit two's complement value. The result is exact with no wrap, including when every coefficient and every sample is −65536.
- R3: `out_valid` is high in the cycle after a cycle in which `in_valid` was high, and low otherwise. `y_out` is loaded at that same clock edge.
- R4: While `in_valid` is low, `y_out` and the internal delay state keep their values. Sample gaps have no effect on the results that follow.
- R5: A coefficient write takes effect at the clock edge where `coef_we` is high. A sample accepted at that same edge still uses the old value, and the next accepted sample uses the new one.
- R6: A write whose `coef_idx` is 10 or more changes no coefficient.
- R7: A synchronous active-high `rst` clears the delay registers, `y_out`, `out_valid` and all ten coefficients to zero.
- R8: A unit impulse followed by zero samples brings out c_0, c_1, … c_9 on successive accepted outputs, and zero after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample accept strobe |
| in_x | input | 17 | Signed input sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_idx | input | 4 | Tap index of the write |
| coef_val | input | 17 | Signed coefficient value |
| out_valid | output | 1 | Output sample strobe |
| y_out | output | 38 | Signed filtered sample |

## Verification
The bench aims at the points where a shift-and-add tap most easily goes wrong.

- **Extreme values.** Full-scale negative coefficients and samples drive the most negative 4-bit group and the sign weight. A tap that mishandles the sign bit, or a chain that is too narrow, gives wrapped sums.
- **Impulse.** A unit impulse shows any tap that picks the wrong odd multiple or shift, and any chain wired in reverse order.
- **Gaps in the stream.** Random gaps in the sample stream catch a chain that shifts on every clock instead of on every accepted sample.
- **Write timing.** Writes issued in the same cycle as a sample catch a coefficient that is applied one sample early or late.
- **Out-of-range writes.** Writes to indices 10 to 15 expose decoding that folds them onto a real tap.
- **Reset.** A reset in mid-stream must leave both the history and the coefficients at zero.

// File: rtl/smfir_pkg.sv
package smfir_pkg;

  // number of odd multiples held by the shared bank: 1x,3x,...,15x
  localparam int ODD_CNT = 8;

  // trailing-zero count of a non-zero 4-bit group
  function automatic int nib_shift(input logic [3:0] v);
    if (v[0]) return 0;
    else if (v[1]) return 1;
    else if (v[2]) return 2;
    else return 3;
  endfunction

  // index into the odd-multiple bank once the trailing zeros are removed
  function automatic logic [2:0] nib_index(input logic [3:0] v);
    logic [3:0] odd;
    odd = v >> nib_shift(v);
    return odd[3:1];
  endfunction

endpackage

// File: rtl/smfir_precomp.sv
module smfir_precomp
  import smfir_pkg::*;
#(
  parameter int DATA_W = 17,
  parameter int MW     = DATA_W + 4
) (
  input  logic signed [DATA_W-1:0]      x,
  output logic [ODD_CNT-1:0][MW-1:0]    mult
);

  logic signed [MW-1:0] xe;
  assign xe = {{(MW-DATA_W){x[DATA_W-1]}}, x};

  for (genvar j = 0; j < ODD_CNT; j++) begin : g_odd
    localparam logic [3:0] K = 4'(2*j + 1);
    logic signed [MW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int b = 0; b < 4; b++) begin
        if (K[b]) acc = acc + (xe <<< b);
      end
    end
    assign mult[j] = acc;
  end

endmodule

// File: rtl/smfir_seladd.sv
module smfir_seladd
  import smfir_pkg::*;
#(
  parameter int DATA_W = 17,
  parameter int COEF_W = 17,
  parameter int MW     = DATA_W + 4,
  parameter int PW     = DATA_W + COEF_W
) (
  input  logic [ODD_CNT-1:0][MW-1:0] mult,
  input  logic [COEF_W-1:0]          coef,
  output logic signed [PW-1:0]       prod
);

  localparam int NNIB = (COEF_W - 1) / 4;

  logic signed [PW-1:0] acc;
  logic signed [PW-1:0] term;
  logic signed [PW-1:0] base;
  logic [3:0]           nib;

  always_comb begin
    acc  = '0;
    term = '0;
    nib  = '0;
    for (int i = 0; i < NNIB; i++) begin
      nib = coef[4*i +: 4];
      if (nib != 4'd0) begin
        term = PW'($signed(mult[nib_index(nib)]));
        acc  = acc + (term <<< (nib_shift(nib) + 4*i));
      end
    end
    base = PW'($signed(mult[0]));
    if (coef[COEF_W-1]) acc = acc - (base <<< (COEF_W - 1));
    prod = acc;
  end

endmodule

// File: rtl/smfir_tdl.sv
module smfir_tdl #(
  parameter int NTAPS = 10,
  parameter int PW    = 34,
  parameter int ACC_W = 38
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          adv,
  input  logic [NTAPS-1:0][PW-1:0]      prods,
  output logic                          vld_q,
  output logic signed [ACC_W-1:0]       y_q
);

  // st[k] holds the partial sum of transposed stage k+1
  logic signed [ACC_W-1:0] st [NTAPS-1];
  logic signed [ACC_W-1:0] pe [NTAPS];

  for (genvar t = 0; t < NTAPS; t++) begin : g_ext
    assign pe[t] = ACC_W'($signed(prods[t]));
  end

  for (genvar k = 0; k < NTAPS-1; k++) begin : g_stage
    if (k == NTAPS-2) begin : g_last
      always_ff @(posedge clk) begin
        if (rst)      st[k] <= '0;
        else if (adv) st[k] <= pe[k+1];
      end
    end else begin : g_mid
      always_ff @(posedge clk) begin
        if (rst)      st[k] <= '0;
        else if (adv) st[k] <= pe[k+1] + st[k+1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y_q   <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= adv;
      if (adv) y_q <= pe[0] + st[0];
    end
  end

endmodule

// File: rtl/shared_mult_fir.sv
module shared_mult_fir
  import smfir_pkg::*;
#(
  parameter int DATA_W = 17,
  parameter int COEF_W = 17,
  parameter int NTAPS  = 10,
  parameter int ACC_W  = 38,
  parameter int IDX_W  = $clog2(NTAPS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_x,
  input  logic                     coef_we,
  input  logic [IDX_W-1:0]         coef_idx,
  input  logic signed [COEF_W-1:0] coef_val,
  output logic                     out_valid,
  output logic signed [ACC_W-1:0]  y_out
);

  localparam int MW = DATA_W + 4;
  localparam int PW = DATA_W + COEF_W;

  logic [ODD_CNT-1:0][MW-1:0] mult;
  logic [NTAPS-1:0][COEF_W-1:0] coef_q;
  logic [NTAPS-1:0][PW-1:0] prods;

  smfir_precomp #(.DATA_W(DATA_W), .MW(MW)) u_pre (
    .x    (in_x),
    .mult (mult)
  );

  for (genvar t = 0; t < NTAPS; t++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst) coef_q[t] <= '0;
      else if (coef_we && coef_idx == IDX_W'(t)) coef_q[t] <= coef_val;
    end

    logic signed [PW-1:0] p;
    smfir_seladd #(.DATA_W(DATA_W), .COEF_W(COEF_W), .MW(MW), .PW(PW)) u_sa (
      .mult (mult),
      .coef (coef_q[t]),
      .prod (p)
    );
    assign prods[t] = p;
  end

  smfir_tdl #(.NTAPS(NTAPS), .PW(PW), .ACC_W(ACC_W)) u_tdl (
    .clk   (clk),
    .rst   (rst),
    .adv   (in_valid),
    .prods (prods),
    .vld_q (out_valid),
    .y_q   (y_out)
  );

endmodule

// File: rtl/smfir_chk.sv
module smfir_chk #(
  parameter int ACC_W = 38
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_valid,
  input logic [ACC_W-1:0] y_out
);

  assert_valid_follows_R3: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_hold_output_R4: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(y_out));

  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> (!out_valid && y_out == '0));

endmodule

bind shared_mult_fir smfir_chk #(.ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .y_out     (y_out)
);

// File: tb/shared_mult_fir_tb.sv
module shared_mult_fir_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NT = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [16:0] in_x = '0;
  logic coef_we = 1'b0;
  logic [3:0] coef_idx = '0;
  logic signed [16:0] coef_val = '0;
  logic out_valid;
  logic signed [37:0] y_out;

  shared_mult_fir u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
    .coef_we(coef_we), .coef_idx(coef_idx), .coef_val(coef_val),
    .out_valid(out_valid), .y_out(y_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  string cur_req = "R7";

  longint mc [NT];
  longint hx [$];
  longint hc [$];
  longint ey = 0;
  bit ev = 1'b0;

  task automatic model(input bit r, input bit v, input int xv,
                       input bit we, input int idx, input int cv);
    longint s;
    int n;
    if (r) begin
      hx.delete(); hc.delete();
      for (int k = 0; k < NT; k++) mc[k] = 0;
      ey = 0; ev = 1'b0;
      return;
    end
    if (v) begin
      hx.push_back(longint'(xv));
      for (int k = 0; k < NT; k++) hc.push_back(mc[k]);
      n = hx.size() - 1;
      s = 0;
      for (int k = 0; k < NT; k++)
        if (n - k >= 0) s += hc[(n-k)*NT + k] * hx[n-k];
      ey = s;
    end
    ev = v;
    if (we && idx < NT) mc[idx] = longint'(cv);
  endtask

  task automatic step(input bit r, input bit v, input int xv,
                      input bit we, input int idx, input int cv);
    rst = r; in_valid = v; in_x = 17'(xv);
    coef_we = we; coef_idx = 4'(idx); coef_val = 17'(cv);
    @(posedge clk);
    model(r, v, xv, we, idx, cv);
    @(negedge clk);
    n_cmp++;
    if (out_valid !== ev || longint'(y_out) != ey) begin
      n_bad++;
      $display("FAIL %s: out_valid=%0b y=%0d expected out_valid=%0b y=%0d",
               cur_req, out_valid, longint'(y_out), ev, ey);
    end
  endtask

  task automatic load_all(input int c [NT]);
    for (int k = 0; k < NT; k++) step(0, 0, 0, 1, k, c[k]);
  endtask

  initial begin : watchdog
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        n_bad++;
        $display("FAIL watchdog: run hung, actual cycles=%0d expected < 200000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin : stim
    int cs [NT];
    cs = '{3, -7, 12, 100, -1, 0, 65535, -65536, 255, 4097};
    // R7: reset state
    cur_req = "R7";
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0);

    load_all(cs);
    // R8: impulse brings out coefficients in order
    cur_req = "R8";
    step(0, 1, 1, 0, 0, 0);
    for (int i = 0; i < 12; i++) step(0, 1, 0, 0, 0, 0);

    // R1: step input
    cur_req = "R1";
    for (int i = 0; i < 14; i++) step(0, 1, 1000, 0, 0, 0);

    // R4: gaps in the stream
    cur_req = "R4";
    for (int i = 0; i < 20; i++) step(0, (i % 3) != 1, i*37 - 300, 0, 0, 0);

    // R3: valid latency with single-cycle pulses
    cur_req = "R3";
    for (int i = 0; i < 8; i++) step(0, i[0], 5 - i, 0, 0, 0);

    // R2: extreme values, every coefficient -65536
    cur_req = "R2";
    for (int k = 0; k < NT; k++) step(0, 0, 0, 1, k, -65536);
    for (int i = 0; i < 12; i++) step(0, 1, -65536, 0, 0, 0);
    for (int i = 0; i < 12; i++) step(0, 1, 65535, 0, 0, 0);

    // R5: write in same cycle as an accepted sample
    cur_req = "R5";
    load_all(cs);
    for (int i = 0; i < 6; i++) step(0, 1, 200 + i, (i == 2), 0, 9999);
    step(0, 1, -77, 1, 9, -12345);
    for (int i = 0; i < 11; i++) step(0, 1, i, 0, 0, 0);

    // R6: out-of-range index writes are ignored
    cur_req = "R6";
    for (int j = 10; j < 16; j++) step(0, 1, 321, 1, j, 22222);
    for (int i = 0; i < 11; i++) step(0, 1, 1, 0, 0, 0);

    // R1: random samples, gaps and writes
    cur_req = "R1";
    for (int i = 0; i < 300; i++) begin
      int xv, cv, idx;
      bit v, we;
      v   = ($urandom_range(0, 3) != 0);
      we  = ($urandom_range(0, 9) == 0);
      xv  = int'($urandom_range(0, 131071)) - 65536;
      cv  = int'($urandom_range(0, 131071)) - 65536;
      idx = int'($urandom_range(0, 15));
      step(0, v, xv, we, idx, cv);
    end

    // R7: reset in mid-stream clears history and coefficients
    cur_req = "R7";
    step(1, 1, 999, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 12; i++) step(0, 1, 4000 - i, 0, 0, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule